// File: doc/BRIEF.md
# Configurable GPIO Port Bank

This block is one bank of general-purpose pins behind a small synchronous register bus. Software sets each pin's role through a mode register. A pin can be a general input, a general output driven from an output latch, or a special-function pin that passes an alternate-function value to the pad. A separate register holds the pull-up controls, which are active low. Reads of the data register merge two sources: the synchronized pad level for pins in input mode, and the output latch for all other pins.

A parameter selects an output-only variant. In that variant each pin has a single mode bit: 0 means general output and 1 means special function. The variant has no input mode and no pull-up register, and the data latch has no effect on a pin in special function. The standard variant supports up to 16 pins. The output-only variant supports up to 32 pins.

Each bank decodes a byte offset within its 0x10-byte window. Offset 0x0 is the mode register, 0x4 the data register and 0x8 the pull-up register. Address bits [1:0] are ignored. The register bus is a plain control interface with no back-pressure. A read request is answered exactly one cycle later with `rd_valid` high for one cycle. A write takes effect at the clock edge that samples `wr_en`.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, the mode, data and pull-up registers read 0. In the standard bank every pin then has `pin_oe`=0 and `pin_alt_sel`=0, and every `pull_en` bit is 1.
- R2: In the standard bank, pin n takes its mode from mode-register bits [2n+1:2n]. Mode 00 is a general input, with `pin_oe`=0 and `pin_alt_sel`=0.
- R3: Mode 01 is a general output. The pin has `pin_oe`=1 and `pin_alt_sel`=0, and `pin_out` equals that pin's data latch bit.
- R4: Modes 10 and 11 both select the special function. The pin has `pin_alt_sel`=1 and `pin_oe`=1, and `pin_out` equals `alt_out` for that pin, whatever the data latch holds.
- R5: For a pin in input mode, data-register bit n returns `pin_in[n]` after a two-flop synchronizer. An input level held for three cycles before a read request is returned.
- R6: For a pin not in input mode, data-register bit n returns the last value written to the data latch.
- R7: Pull-up bit n equal to 0 sets `pull_en[n]`=1, and bit n equal to 1 clears it. This holds in every pin mode.
- R8: Data bits above the implemented pin or field count read as 0. Offset 0xC reads 0, and a write to 0xC changes no register.
- R9: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high, and `rdata` is valid in that cycle.
- R10: In the output-only variant, mode bit n equal to 0 gives `pin_oe`=1 and `pin_out`=latch bit n. Mode bit n equal to 1 gives `pin_alt_sel`=1 and `pin_out`=`alt_out[n]`. Data reads return the latch for every pin.
- R11: In the output-only variant, offset 0x8 reads 0, `pull_en` is always 0, and the mode register keeps only its low NUM_PINS bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| addr | input | 4 | Byte offset within the bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| pin_in | input | NUM_PINS | Raw pad input levels |
| alt_out | input | NUM_PINS | Alternate-function output values |
| pin_out | output | NUM_PINS | Value driven toward each pad |
| pin_oe | output | NUM_PINS | Pad output enable |
| pin_alt_sel | output | NUM_PINS | Special-function select per pin |
| pull_en | output | NUM_PINS | Pull-up enable per pin, active high |

## Verification
A corrupted mode field shows at the pin outputs on the cycle after the write that should have set it. The pin's enable or alternate select is wrong, or its data readback takes the wrong source. A latch or pull-up fault is visible at once on `pin_out` or `pull_en`, and on the next read of that register. A synchronizer with the wrong depth shows as a stale or early input level in a read issued a set number of cycles after the pad changes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PULL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_OUTPUT = 2'b01,
    PM_ALT_A  = 2'b10,
    PM_ALT_B  = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter bit          OUT_ONLY = 1'b0,
  parameter int unsigned MODE_W   = OUT_ONLY ? NUM_PINS : 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [3:0]          addr,
  input  logic [BUS_W-1:0]    wdata,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] is_input,
  output logic [MODE_W-1:0]   mode_q,
  output logic [NUM_PINS-1:0] latch_q,
  output logic [NUM_PINS-1:0] pull_q,
  output logic [BUS_W-1:0]    rdata,
  output logic                rd_valid
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr[3:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      latch_q <= '0;
      pull_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_MODE: mode_q  <= wdata[MODE_W-1:0];
        SEL_DATA: latch_q <= wdata[NUM_PINS-1:0];
        SEL_PULL: if (!OUT_ONLY) pull_q <= wdata[NUM_PINS-1:0];
        default:  ;
      endcase
    end
  end

  logic [BUS_W-1:0]    rd_next;
  logic [NUM_PINS-1:0] data_view;

  assign data_view = (pin_sync & is_input) | (latch_q & ~is_input);

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_MODE: rd_next[MODE_W-1:0]   = mode_q;
      SEL_DATA: rd_next[NUM_PINS-1:0] = data_view;
      SEL_PULL: if (!OUT_ONLY) rd_next[NUM_PINS-1:0] = pull_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end

  AST_HOLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[3:2] == 2'b11) |=> ($stable(mode_q) && $stable(latch_q) && $stable(pull_q))); // R8
endmodule

// File: rtl/gpio_bank_pinmux.sv
module gpio_bank_pinmux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter bit          OUT_ONLY = 1'b0,
  parameter int unsigned MODE_W   = OUT_ONLY ? NUM_PINS : 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   mode_q,
  input  logic [NUM_PINS-1:0] latch_q,
  input  logic [NUM_PINS-1:0] pull_q,
  input  logic [NUM_PINS-1:0] alt_out,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_alt_sel,
  output logic [NUM_PINS-1:0] pull_en,
  output logic [NUM_PINS-1:0] is_input
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (OUT_ONLY) begin : g_oo
      logic special;
      assign special        = mode_q[p];
      assign pin_alt_sel[p] = special;
      assign pin_oe[p]      = 1'b1;
      assign pin_out[p]     = special ? alt_out[p] : latch_q[p];
      assign pull_en[p]     = 1'b0;
      assign is_input[p]    = 1'b0;
    end else begin : g_std
      pin_mode_e mode;
      logic      special;
      assign mode           = pin_mode_e'(mode_q[2*p+1:2*p]);
      assign special        = (mode == PM_ALT_A) || (mode == PM_ALT_B);
      assign pin_alt_sel[p] = special;
      assign pin_oe[p]      = special || (mode == PM_OUTPUT);
      assign pin_out[p]     = special ? alt_out[p] : latch_q[p];
      assign pull_en[p]     = ~pull_q[p];
      assign is_input[p]    = (mode == PM_INPUT);
    end

    AST_ALT_DRIVES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      pin_alt_sel[p] |-> pin_oe[p]); // R4
    AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      is_input[p] |-> (!pin_oe[p] && !pin_alt_sel[p])); // R2
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter bit          OUT_ONLY = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [3:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                rd_valid,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] alt_out,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_alt_sel,
  output logic [NUM_PINS-1:0] pull_en
);
  localparam int unsigned MODE_W = OUT_ONLY ? NUM_PINS : 2 * NUM_PINS;

  logic [MODE_W-1:0]   mode_q;
  logic [NUM_PINS-1:0] latch_q;
  logic [NUM_PINS-1:0] pull_q;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] is_input;

  gpio_bank_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_bank_regs #(.NUM_PINS(NUM_PINS), .OUT_ONLY(OUT_ONLY), .MODE_W(MODE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .pin_sync (pin_sync),
    .is_input (is_input),
    .mode_q   (mode_q),
    .latch_q  (latch_q),
    .pull_q   (pull_q),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  gpio_bank_pinmux #(.NUM_PINS(NUM_PINS), .OUT_ONLY(OUT_ONLY), .MODE_W(MODE_W)) u_mux (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .latch_q     (latch_q),
    .pull_q      (pull_q),
    .alt_out     (alt_out),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .pin_alt_sel (pin_alt_sel),
    .pull_en     (pull_en),
    .is_input    (is_input)
  );

  AST_PULL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!OUT_ONLY && wr_en && addr[3:2] == 2'b10) |=> (pull_en == ~$past(wdata[NUM_PINS-1:0]))); // R7
endmodule

// File: tb/gpio_port_bank_tb_top.sv
module gpio_port_bank_tb_top;
  localparam int unsigned NP  = 16;
  localparam int unsigned NPO = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          wr_en = 0, rd_en = 0;
  logic [3:0]    addr = 0;
  logic [31:0]   wdata = 0, rdata;
  logic          rd_valid;
  logic [NP-1:0] pin_in = 0, alt_out = 0, pin_out, pin_oe, pin_alt_sel, pull_en;

  logic           owr_en = 0, ord_en = 0;
  logic [3:0]     oaddr = 0;
  logic [31:0]    owdata = 0, ordata;
  logic           ord_valid;
  logic [NPO-1:0] opin_in = 0, oalt_out = 0, opin_out, opin_oe, opin_alt_sel, opull_en;

  gpio_port_bank #(.NUM_PINS(NP), .OUT_ONLY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pin_in(pin_in),
    .alt_out(alt_out), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_alt_sel(pin_alt_sel), .pull_en(pull_en));

  gpio_port_bank #(.NUM_PINS(NPO), .OUT_ONLY(1'b1)) dut_oo_i (
    .clk(clk), .rst_n(rst_n), .wr_en(owr_en), .rd_en(ord_en), .addr(oaddr),
    .wdata(owdata), .rdata(ordata), .rd_valid(ord_valid), .pin_in(opin_in),
    .alt_out(oalt_out), .pin_out(opin_out), .pin_oe(opin_oe),
    .pin_alt_sel(opin_alt_sel), .pull_en(opull_en));

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          oo;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit oo, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    if (oo) begin owr_en = 1; oaddr = a; owdata = d; end
    else    begin wr_en = 1;  addr = a;  wdata = d;  end
    @(negedge clk);
    owr_en = 0; wr_en = 0;
  endtask

  task automatic rd(bit oo, logic [3:0] a, logic [31:0] e, string tag);
    rd_item_t it;
    it.oo = oo; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    if (oo) begin ord_en = 1; oaddr = a; end
    else    begin rd_en = 1;  addr = a;  end
    @(negedge clk);
    ord_en = 0; rd_en = 0;
  endtask

  // Monitor: pops one expected item per response; R9 a response with nothing pending fails
  always @(negedge clk) begin
    if (rst_n && (rd_valid || ord_valid)) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected rd_valid actual=1 expected=0");
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(it.tag, it.oo ? ordata : rdata, it.exp);
        if (it.oo != ord_valid) begin
          checks++; errors++;
          $display("FAIL R9 response on wrong bank actual=%0d expected=%0d", ord_valid, it.oo);
        end
      end
    end
  end

  function automatic logic [31:0] mux_exp(logic [31:0] latch, logic [31:0] alt, logic [31:0] sel);
    return (latch & ~sel) | (alt & sel);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe",      {16'h0, pin_oe},      32'h0);
    chk("R1 alt_sel", {16'h0, pin_alt_sel}, 32'h0);
    chk("R1 pull_en", {16'h0, pull_en},     32'h0000_FFFF);
    rd(0, 4'h0, 32'h0, "R1 mode");
    rd(0, 4'h4, 32'h0, "R1 data");
    rd(0, 4'h8, 32'h0, "R1 pull");

    // R2 R3 R4: pin0 in, pin1 out, pin2 mode 10, pin3 mode 11, pins 4..15 out
    alt_out = 16'hAAAA;
    wr(0, 4'h0, 32'h5555_55E4);
    wr(0, 4'h4, 32'hFFFF_F0F3);
    rd(0, 4'h0, 32'h5555_55E4, "R2 mode readback");
    chk("R2 R3 oe",   {16'h0, pin_oe},      32'h0000_FFFE);
    chk("R4 alt_sel", {16'h0, pin_alt_sel}, 32'h0000_000C);
    chk("R3 R4 pin_out", {16'h0, pin_out}, mux_exp(32'hF0F3, 32'hAAAA, 32'hC));
    alt_out = 16'h5555;
    #1 chk("R4 alt follow", {16'h0, pin_out}, mux_exp(32'hF0F3, 32'h5555, 32'hC));

    // R5 R6 R8: data readback, pin0 from synchronizer, rest from latch, upper bits 0
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    rd(0, 4'h4, 32'h0000_F0F2, "R5 R6 R8 data in=0");
    pin_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    rd(0, 4'h4, 32'h0000_F0F3, "R5 R6 data in=1");

    // R7 pull-ups, independent of mode
    wr(0, 4'h8, 32'hFFFF_00FF);
    chk("R7 pull_en", {16'h0, pull_en}, 32'h0000_FF00);
    rd(0, 4'h8, 32'h0000_00FF, "R7 R8 pull readback");
    wr(0, 4'h0, 32'h0);
    chk("R7 pull_en after mode change", {16'h0, pull_en}, 32'h0000_FF00);
    chk("R2 all inputs oe", {16'h0, pin_oe}, 32'h0);
    pin_in = 16'h1234;
    repeat (3) @(negedge clk);
    rd(0, 4'h4, 32'h0000_1234, "R5 all inputs");

    // R8 hole at 0xC
    wr(0, 4'hC, 32'hFFFF_FFFF);
    rd(0, 4'hC, 32'h0, "R8 hole read");
    rd(0, 4'h0, 32'h0, "R8 mode unchanged");
    rd(0, 4'h8, 32'h0000_00FF, "R8 pull unchanged");
    chk("R8 oe unchanged", {16'h0, pin_oe}, 32'h0);

    // R10 R11 output-only variant
    chk("R10 oo reset oe",      {9'h0, opin_oe},  32'h007F_FFFF);
    chk("R10 oo reset pin_out", {9'h0, opin_out}, 32'h0);
    chk("R11 oo pull_en",       {9'h0, opull_en}, 32'h0);
    wr(1, 4'h0, 32'hFFFF_FFFF);
    rd(1, 4'h0, 32'h007F_FFFF, "R11 oo mode width");
    oalt_out = 23'h000005;
    wr(1, 4'h0, 32'h0000_0F0F);
    wr(1, 4'h4, 32'hFFFF_FFFF);
    chk("R10 oo alt_sel", {9'h0, opin_alt_sel}, 32'h0000_0F0F);
    chk("R10 oo pin_out", {9'h0, opin_out}, mux_exp(32'h007F_FFFF, 32'h5, 32'hF0F));
    chk("R10 oo oe",      {9'h0, opin_oe},  32'h007F_FFFF);
    opin_in = '0;
    repeat (3) @(negedge clk);
    rd(1, 4'h4, 32'h007F_FFFF, "R10 oo data from latch");
    wr(1, 4'h8, 32'h0);
    rd(1, 4'h8, 32'h0, "R11 oo no pull register");
    chk("R11 oo pull_en after write", {9'h0, opull_en}, 32'h0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule